// File: doc/BRIEF.md
# Sorted Control-Record Forwarder

This block moves per-packet control records from four per-channel record FIFOs into a single status FIFO, in the packet order given by an external ordering queue. Each ordering-queue entry is a channel index. The block takes one entry and then reads that channel's six-word record: one identifier word, four timestamp words and one length word. It throws away the identifier. It forwards the timestamp words and the length word, each marked by its own write strobe.

All three neighbours are first-word-fall-through FIFOs that the block does not contain. The block sees their empty or full flags and their head words. It drives a read pulse or a write pulse for each word it takes or gives. The record layout (identifier words, timestamp words, length words), the word width and the channel count are parameters. A parameter also sets whether the discarded identifier word has to wait for room in the status FIFO.

Top module: `ctrl_rec_fwd`

## Requirements
- R1: After reset is released, with the ordering queue empty, `ord_rd_o`, `rec_rd_o`, `ts_wr_o` and `len_wr_o` are all low.
- R2: `ord_rd_o` pulses only when the ordering queue is non-empty and no record is in progress, and exactly one entry is taken for each record.
- R3: A queue entry whose 2-bit value is c selects channel c. Only bit c of `rec_rd_o` may then pulse, and the record word comes from lane c of `rec_data_i`, bits [16c+15:16c].
- R4: Exactly six words are read from the selected channel for each entry. The first word (identifier) is read with neither write strobe raised.
- R5: Words two to five of a record are each presented on `stat_data_o` with `ts_wr_o` high, in the order they were read (timestamp least-significant word first).
- R6: The sixth word of a record is presented on `stat_data_o` with `len_wr_o` high, after exactly four timestamp writes.
- R7: `ts_wr_o` and `len_wr_o` are never high together, and each write strobe coincides with a record read.
- R8: While the selected record FIFO reports empty, no record read and no write takes place.
- R9: While `stat_full_i` is high, no write takes place. The identifier word is still read and discarded.
- R10: The empty flags of the channels that are not selected have no effect on the forwarded word stream.
- R11: A new queue entry is taken no earlier than the cycle after the length word of the current record is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ord_empty_i | input | 1 | Ordering queue empty |
| ord_idx_i | input | 2 | Head entry of the ordering queue: channel index |
| ord_rd_o | output | 1 | Pop the ordering queue |
| rec_empty_i | input | 4 | Empty flag of each record FIFO |
| rec_data_i | input | 64 | Head words of the record FIFOs, 16 bits per channel, channel 0 lowest |
| rec_rd_o | output | 4 | Pop strobe for each record FIFO |
| stat_full_i | input | 1 | Status FIFO full |
| stat_data_o | output | 16 | Word to write into the status FIFO |
| ts_wr_o | output | 1 | Write strobe for a timestamp word |
| len_wr_o | output | 1 | Write strobe for the length word |

## Verification
The hardest situation to reach from the ports is a record that is stalled partway through. In that case the status FIFO is full after the identifier has already been discarded, or the selected channel runs dry while the other channels carry data. To get there, the bench replays its record table a second time with stall patterns derived from the cycle count. These patterns force the full flag and individual empty flags on and off, and the forwarded stream must come out word for word as before. Two directed cases then hold the full flag across an entire record, and queue an entry before its record words arrive.

// File: rtl/ctrl_rec_fwd_pkg.sv
package ctrl_rec_fwd_pkg;

   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_DRAIN = 1'b1
   } seq_state_e;

   typedef enum logic [1:0] {
      WK_DROP = 2'd0,
      WK_TS   = 2'd1,
      WK_LEN  = 2'd2
   } word_kind_e;

endpackage

// File: rtl/crf_word_class.sv
module crf_word_class
   import ctrl_rec_fwd_pkg::*;
#(
   parameter int ID_WORDS  = 1,
   parameter int TS_WORDS  = 4,
   parameter int LEN_WORDS = 1,
   parameter int CNT_W     = 3
) (
   input  logic [CNT_W-1:0] word_idx_i,
   output word_kind_e       kind_o,
   output logic             last_o
);

   localparam int REC_WORDS = ID_WORDS + TS_WORDS + LEN_WORDS;
   localparam logic [CNT_W-1:0] TS_FIRST  = CNT_W'(ID_WORDS);
   localparam logic [CNT_W-1:0] LEN_FIRST = CNT_W'(ID_WORDS + TS_WORDS);
   localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(REC_WORDS - 1);

   always_comb begin
      if (word_idx_i < TS_FIRST) begin
         kind_o = WK_DROP;
      end else if (word_idx_i < LEN_FIRST) begin
         kind_o = WK_TS;
      end else begin
         kind_o = WK_LEN;
      end
   end

   assign last_o = (word_idx_i == LAST_IDX);

endmodule

// File: rtl/crf_chan_sel.sv
module crf_chan_sel #(
   parameter int NUM_CH = 4,
   parameter int WORD_W = 16,
   parameter int IDX_W  = 2
) (
   input  logic [IDX_W-1:0]         sel_i,
   input  logic                     rd_en_i,
   input  logic [NUM_CH-1:0]        rec_empty_i,
   input  logic [NUM_CH*WORD_W-1:0] rec_data_i,
   output logic                     sel_empty_o,
   output logic [WORD_W-1:0]        sel_data_o,
   output logic [NUM_CH-1:0]        rec_rd_o
);

   assign sel_empty_o = rec_empty_i[sel_i];
   assign sel_data_o  = rec_data_i[sel_i*WORD_W +: WORD_W];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
      assign rec_rd_o[c] = rd_en_i && (sel_i == IDX_W'(c));
   end

endmodule

// File: rtl/crf_seq.sv
module crf_seq
   import ctrl_rec_fwd_pkg::*;
#(
   parameter int IDX_W     = 2,
   parameter int CNT_W     = 3,
   parameter bit ID_WAITS  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ord_empty_i,
   input  logic [IDX_W-1:0] ord_idx_i,
   output logic             ord_rd_o,
   input  logic             sel_empty_i,
   input  logic             stat_full_i,
   input  word_kind_e       kind_i,
   input  logic             last_i,
   output logic [IDX_W-1:0] sel_o,
   output logic [CNT_W-1:0] word_idx_o,
   output logic             rd_en_o,
   output logic             ts_wr_o,
   output logic             len_wr_o
);

   seq_state_e       state_q;
   logic [IDX_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             space_ok;
   logic             adv;

   if (ID_WAITS) begin : g_id_waits
      assign space_ok = !stat_full_i;
   end else begin : g_id_free
      assign space_ok = !stat_full_i || (kind_i == WK_DROP);
   end

   assign ord_rd_o = (state_q == ST_IDLE) && !ord_empty_i;
   assign adv      = (state_q == ST_DRAIN) && !sel_empty_i && space_ok;
   assign rd_en_o  = adv;
   assign ts_wr_o  = adv && (kind_i == WK_TS);
   assign len_wr_o = adv && (kind_i == WK_LEN);

   assign sel_o      = sel_q;
   assign word_idx_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= '0;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (ord_rd_o) begin
                  sel_q   <= ord_idx_i;
                  cnt_q   <= '0;
                  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (adv) begin
                  cnt_q <= cnt_q + 1'b1;
                  if (last_i) begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ctrl_rec_fwd.sv
module ctrl_rec_fwd
   import ctrl_rec_fwd_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int WORD_W    = 16,
   parameter int ID_WORDS  = 1,
   parameter int TS_WORDS  = 4,
   parameter int LEN_WORDS = 1,
   parameter bit ID_WAITS  = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ord_empty_i,
   input  logic [$clog2(NUM_CH)-1:0]     ord_idx_i,
   output logic                          ord_rd_o,
   input  logic [NUM_CH-1:0]             rec_empty_i,
   input  logic [NUM_CH*WORD_W-1:0]      rec_data_i,
   output logic [NUM_CH-1:0]             rec_rd_o,
   input  logic                          stat_full_i,
   output logic [WORD_W-1:0]             stat_data_o,
   output logic                          ts_wr_o,
   output logic                          len_wr_o
);

   localparam int IDX_W     = $clog2(NUM_CH);
   localparam int REC_WORDS = ID_WORDS + TS_WORDS + LEN_WORDS;
   localparam int CNT_W     = $clog2(REC_WORDS);

   if (NUM_CH < 2 || NUM_CH != (1 << IDX_W)) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (WORD_W < 1) begin : g_bad_w
      $error("WORD_W must be positive");
   end
   if (TS_WORDS < 1 || LEN_WORDS != 1 || ID_WORDS < 0) begin : g_bad_rec
      $error("record layout needs TS_WORDS >= 1, LEN_WORDS == 1, ID_WORDS >= 0");
   end

   word_kind_e         kind;
   logic               last;
   logic [IDX_W-1:0]   sel;
   logic [CNT_W-1:0]   word_idx;
   logic               rd_en;
   logic               sel_empty;

   crf_word_class #(
      .ID_WORDS (ID_WORDS),
      .TS_WORDS (TS_WORDS),
      .LEN_WORDS(LEN_WORDS),
      .CNT_W    (CNT_W)
   ) class_i (
      .word_idx_i(word_idx),
      .kind_o    (kind),
      .last_o    (last)
   );

   crf_chan_sel #(
      .NUM_CH(NUM_CH),
      .WORD_W(WORD_W),
      .IDX_W (IDX_W)
   ) sel_i (
      .sel_i      (sel),
      .rd_en_i    (rd_en),
      .rec_empty_i(rec_empty_i),
      .rec_data_i (rec_data_i),
      .sel_empty_o(sel_empty),
      .sel_data_o (stat_data_o),
      .rec_rd_o   (rec_rd_o)
   );

   crf_seq #(
      .IDX_W   (IDX_W),
      .CNT_W   (CNT_W),
      .ID_WAITS(ID_WAITS)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ord_empty_i(ord_empty_i),
      .ord_idx_i  (ord_idx_i),
      .ord_rd_o   (ord_rd_o),
      .sel_empty_i(sel_empty),
      .stat_full_i(stat_full_i),
      .kind_i     (kind),
      .last_i     (last),
      .sel_o      (sel),
      .word_idx_o (word_idx),
      .rd_en_o    (rd_en),
      .ts_wr_o    (ts_wr_o),
      .len_wr_o   (len_wr_o)
   );

endmodule

// File: rtl/ctrl_rec_fwd_chk.sv
module ctrl_rec_fwd_chk #(
   parameter int NUM_CH   = 4,
   parameter int TS_WORDS = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ord_empty_i,
   input logic                      ord_rd_o,
   input logic [NUM_CH-1:0]         rec_empty_i,
   input logic [NUM_CH-1:0]         rec_rd_o,
   input logic                      stat_full_i,
   input logic                      ts_wr_o,
   input logic                      len_wr_o
);

   localparam int TCW = $clog2(TS_WORDS + 1) + 1;

   logic [TCW-1:0] ts_cnt_q;
   logic           in_rec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_cnt_q <= '0;
         in_rec_q <= 1'b0;
      end else begin
         if (len_wr_o) begin
            ts_cnt_q <= '0;
         end else if (ts_wr_o) begin
            ts_cnt_q <= ts_cnt_q + 1'b1;
         end
         if (ord_rd_o) begin
            in_rec_q <= 1'b1;
         end else if (len_wr_o) begin
            in_rec_q <= 1'b0;
         end
      end
   end

   // R2
   pop_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ord_rd_o |-> !ord_empty_i);

   // R11
   pop_between_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ord_rd_o |-> (!in_rec_q && rec_rd_o == '0));

   // R3
   single_channel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rec_rd_o));

   // R2
   read_inside_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_rd_o != '0) |-> in_rec_q);

   // R8
   read_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_rd_o & rec_empty_i) == '0);

   // R7
   strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ts_wr_o && len_wr_o));

   // R7
   write_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_wr_o || len_wr_o) |-> (rec_rd_o != '0));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_wr_o || len_wr_o) |-> !stat_full_i);

   // R5
   ts_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_wr_o |-> (ts_cnt_q < TCW'(TS_WORDS)));

   // R6
   len_after_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_wr_o |-> (ts_cnt_q == TCW'(TS_WORDS)));

   // R11
   no_pop_after_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_wr_o |=> (rec_rd_o == '0));

endmodule

bind ctrl_rec_fwd ctrl_rec_fwd_chk #(
   .NUM_CH  (NUM_CH),
   .TS_WORDS(TS_WORDS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ord_empty_i(ord_empty_i),
   .ord_rd_o   (ord_rd_o),
   .rec_empty_i(rec_empty_i),
   .rec_rd_o   (rec_rd_o),
   .stat_full_i(stat_full_i),
   .ts_wr_o    (ts_wr_o),
   .len_wr_o   (len_wr_o)
);

// File: tb/ctrl_rec_fwd_tb_top.sv
module ctrl_rec_fwd_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ord_empty_i;
   logic [1:0]  ord_idx_i;
   logic        ord_rd_o;
   logic [3:0]  rec_empty_i;
   logic [63:0] rec_data_i;
   logic [3:0]  rec_rd_o;
   logic        stat_full_i;
   logic [15:0] stat_data_o;
   logic        ts_wr_o;
   logic        len_wr_o;

   always #2.5 clk = ~clk;

   ctrl_rec_fwd dut_i (
      .clk(clk), .rst_n(rst_n),
      .ord_empty_i(ord_empty_i), .ord_idx_i(ord_idx_i), .ord_rd_o(ord_rd_o),
      .rec_empty_i(rec_empty_i), .rec_data_i(rec_data_i), .rec_rd_o(rec_rd_o),
      .stat_full_i(stat_full_i), .stat_data_o(stat_data_o),
      .ts_wr_o(ts_wr_o), .len_wr_o(len_wr_o)
   );

   // stimulus table: {channel, seed}; expected words derive from word_of()
   localparam logic [9:0] VEC [12] = '{
      {2'd0, 8'h11}, {2'd1, 8'h22}, {2'd2, 8'h33}, {2'd3, 8'h44},
      {2'd3, 8'h55}, {2'd3, 8'h66}, {2'd0, 8'h77}, {2'd2, 8'h88},
      {2'd1, 8'h99}, {2'd1, 8'hAA}, {2'd0, 8'hBB}, {2'd2, 8'hCC}
   };

   logic [15:0] ch_mem [4][128];
   int          ch_wp [4];
   int          ch_rp [4];
   logic [1:0]  oq_mem [64];
   int          oq_wp, oq_rp;
   logic [15:0] exp_w [256];
   logic        exp_len [256];
   int          exp_wp, exp_rp;
   int          words_left;
   logic [1:0]  cur_ch;
   int          pops, reads, writes, checks, fails, cyc;
   logic        noise_en, force_full;

   function automatic logic [15:0] word_of(logic [1:0] ch, logic [7:0] seed, int k);
      return {ch, 3'(k), 3'b101, seed};
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic push_ord(logic [1:0] ch);
      oq_mem[oq_wp % 64] = ch;
      oq_wp++;
   endtask

   task automatic push_words(logic [1:0] ch, logic [7:0] seed);
      for (int k = 0; k < 6; k++) begin
         ch_mem[ch][(ch_wp[ch] + k) % 128] = word_of(ch, seed, k);
         if (k > 0) begin
            exp_w[exp_wp % 256]   = word_of(ch, seed, k);
            exp_len[exp_wp % 256] = (k == 5);
            exp_wp++;
         end
      end
      ch_wp[ch] += 6;
   endtask

   task automatic push_rec(logic [1:0] ch, logic [7:0] seed);
      push_words(ch, seed);
      push_ord(ch);
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 2000; i++) begin
         if (exp_rp == exp_wp && words_left == 0 && oq_rp == oq_wp) break;
         @(posedge clk);
      end
   endtask

   // drive at negedge, check and commit handshakes shortly after
   always @(negedge clk) begin
      cyc++;
      ord_empty_i = (oq_wp == oq_rp) || !rst_n;
      ord_idx_i   = oq_mem[oq_rp % 64];
      for (int c = 0; c < 4; c++) begin
         rec_empty_i[c] = (ch_wp[c] == ch_rp[c]) || !rst_n ||
                          (noise_en && ((cyc + c) % 4 == 0));
         rec_data_i[c*16 +: 16] = ch_mem[c][ch_rp[c] % 128];
      end
      stat_full_i = force_full || (noise_en && (cyc % 3 == 0));
      #1;
      if (rst_n) begin
         if (ord_rd_o) begin
            chk(!ord_empty_i, "R2 pop on empty queue", 32'(ord_empty_i), 0);
            chk(words_left == 0, "R11 pop inside record", 32'(words_left), 0);
            cur_ch     = ord_idx_i;
            oq_rp++;
            words_left = 6;
            pops++;
         end
         if (rec_rd_o != 4'd0) begin
            chk(rec_rd_o == (4'd1 << cur_ch) && words_left != 0,
                "R3 read strobe channel", 32'(rec_rd_o), 32'(4'd1 << cur_ch));
            chk(!rec_empty_i[cur_ch], "R8 read while empty", 32'(rec_empty_i), 0);
            if (words_left == 6) begin
               chk(!ts_wr_o && !len_wr_o, "R4 identifier forwarded",
                   32'({ts_wr_o, len_wr_o}), 0);
            end
            ch_rp[cur_ch]++;
            if (words_left > 0) words_left--;
            reads++;
         end
         if (ts_wr_o || len_wr_o) begin
            chk(!(ts_wr_o && len_wr_o), "R7 both strobes", 32'({ts_wr_o, len_wr_o}), 0);
            chk(rec_rd_o != 4'd0, "R7 write without read", 32'(rec_rd_o), 1);
            chk(!stat_full_i, "R9 write while full", 32'(stat_full_i), 0);
            if (exp_len[exp_rp % 256]) begin
               chk(len_wr_o && stat_data_o == exp_w[exp_rp % 256], "R6 length word",
                   {15'd0, len_wr_o, stat_data_o}, {16'd1, exp_w[exp_rp % 256]});
            end else begin
               chk(ts_wr_o && stat_data_o == exp_w[exp_rp % 256], "R5 timestamp word",
                   {15'd0, ts_wr_o, stat_data_o}, {16'd1, exp_w[exp_rp % 256]});
            end
            exp_rp++;
            writes++;
         end
      end
   end

   initial begin
      int r0, w0, p0;
      ord_empty_i = 1'b1; ord_idx_i = '0; rec_empty_i = '1; rec_data_i = '0;
      stat_full_i = 1'b0;
      oq_wp = 0; oq_rp = 0; exp_wp = 0; exp_rp = 0; words_left = 0; cur_ch = '0;
      pops = 0; reads = 0; writes = 0; checks = 0; fails = 0; cyc = 0;
      noise_en = 1'b0; force_full = 1'b0;
      for (int c = 0; c < 4; c++) begin
         ch_wp[c] = 0;
         ch_rp[c] = 0;
      end
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      // R1: idle after reset with nothing queued
      chk(!ord_rd_o, "R1 ord_rd after reset", 32'(ord_rd_o), 0);
      chk(rec_rd_o == 4'd0, "R1 rec_rd after reset", 32'(rec_rd_o), 0);
      chk(!ts_wr_o && !len_wr_o, "R1 write strobes after reset",
          32'({ts_wr_o, len_wr_o}), 0);

      // table walk, no stalls
      @(posedge clk);
      foreach (VEC[i]) push_rec(VEC[i][9:8], VEC[i][7:0]);
      wait_drain();
      chk(exp_rp == exp_wp, "R5 stream drained", 32'(exp_rp), 32'(exp_wp));
      chk(pops == 12, "R2 one pop per record", 32'(pops), 12);
      chk(reads == 72, "R4 six reads per record", 32'(reads), 72);

      // table walk again with full and empty noise, including unselected channels (R10)
      @(posedge clk);
      noise_en = 1'b1;
      foreach (VEC[i]) push_rec(VEC[i][9:8], VEC[i][7:0] ^ 8'hFF);
      wait_drain();
      noise_en = 1'b0;
      chk(exp_rp == exp_wp, "R10 stream unchanged under noise", 32'(exp_rp), 32'(exp_wp));
      chk(writes == 120, "R10 write count under noise", 32'(writes), 120);

      // R9: full held across a whole record
      @(posedge clk);
      r0 = reads; w0 = writes;
      force_full = 1'b1;
      push_rec(2'd1, 8'hA5);
      repeat (20) @(posedge clk);
      chk(reads - r0 == 1, "R9 only identifier read while full", 32'(reads - r0), 1);
      chk(writes - w0 == 0, "R9 no writes while full", 32'(writes - w0), 0);
      force_full = 1'b0;
      wait_drain();
      chk(writes - w0 == 5, "R6 record completes after full", 32'(writes - w0), 5);

      // R8: entry queued before its record words arrive
      @(posedge clk);
      r0 = reads; p0 = pops;
      push_ord(2'd2);
      repeat (10) @(posedge clk);
      chk(pops - p0 == 1, "R2 entry taken once", 32'(pops - p0), 1);
      chk(reads - r0 == 0, "R8 no read from empty channel", 32'(reads - r0), 0);
      push_words(2'd2, 8'h3C);
      wait_drain();
      chk(reads - r0 == 6, "R4 six reads after data arrives", 32'(reads - r0), 6);
      chk(pops - p0 == 1, "R11 no extra pop", 32'(pops - p0), 1);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule